// File: doc/BRIEF.md
# Per-Bin Power Average and Peak Accumulator

This block sits after a power computation stage in a spectrum analysis datapath. It receives one 32-bit power value per frequency bin, together with that bin's index, in blocks of 256 bins. Over a period of 128 consecutive blocks it keeps, for every bin, a running sum and the largest value seen, along with the index of the block where that largest value first appeared.

When the last bin of the last block in a period is accepted, the block writes the period's results toward external memory. It emits 512 words on a valid/address/data stream: the 256 averages at addresses 0 to 255, then the 256 peak words at addresses 256 to 511. It then starts the next period at once. Results are emitted from a second copy of the storage, so input keeps flowing while they go out.

Top module: `pwr_bin_accum`

## Requirements
- R1: While reset is asserted, and from reset release until the end of the first period, `out_valid` stays low.
- R2: The word written at address `b` (0 to 255) is the sum of the 128 power values received for bin `b` during the period, shifted right by 7 bits, as a 32-bit word.
- R3: The word written at address `256+b` holds, in bits 31:25, the block index (0 to 127, counted from the start of the period) where bin `b` reached its maximum. Bits 24:0 hold bits 31:7 of that maximum.
- R4: When the maximum of a bin occurs in more than one block, the peak word reports the earliest of those blocks.
- R5: Each period's results depend only on that period's input. The first block of a period loads the sums and peaks instead of adding to the previous period's values.
- R6: The cycle after the final input of a period is accepted is idle. In the cycle after that, `out_valid` rises, and it stays high for 512 consecutive cycles with `out_addr` counting 0, 1, ..., 511.
- R7: Input accepted during result emission is never stalled or lost. It counts toward the next period, which is reported correctly.
- R8: The average cannot overflow. A bin receiving 0xFFFFFFFF in all 128 blocks reports an average of 0xFFFFFFFF.
- R9: Cycles with `in_valid` low leave every sum, peak and block count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Power value present this cycle |
| in_bin | input | 8 | Frequency bin index of the value |
| in_power | input | 32 | Unsigned power value |
| out_valid | output | 1 | Result word present this cycle |
| out_addr | output | 9 | Result word address (averages 0-255, peaks 256-511) |
| out_data | output | 32 | Result word |

## Verification
The assertions rely on two properties of the input. Bin indices arrive in ascending order from 0 to 255 in every block, with none skipped or repeated. A full period lasts far longer than the 512 cycles of emission, so one emission always ends before the next begins. The stimulus walks bins strictly in order and creates gaps only by lowering `in_valid` for random single cycles. The second period is driven back to back with the first, so that its opening blocks overlap the emission of the first period's results.

// File: rtl/pwr_bin_accum.sv
module pwr_bin_accum #(
  parameter int DW = 32,
  parameter int BINS = 256,
  parameter int BLOCKS = 128,
  localparam int BW = $clog2(BINS),
  localparam int LB = $clog2(BLOCKS),
  localparam int AW = BW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [BW-1:0] in_bin,
  input  logic [DW-1:0] in_power,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  localparam int SW = DW + LB;

  logic [SW-1:0] sum_m [2][BINS];
  logic [DW-1:0] pk_m  [2][BINS];
  logic [LB-1:0] ix_m  [2][BINS];

  logic          sel;
  logic [LB-1:0] blk;
  logic          emit_on;
  logic [AW-1:0] ecnt;

  wire           osel     = ~sel;
  wire           first    = (blk == '0);
  wire [SW-1:0]  cur_sum  = sum_m[sel][in_bin];
  wire [DW-1:0]  cur_pk   = pk_m[sel][in_bin];
  wire           take     = first || (in_power > cur_pk);
  wire           last_bin = (in_bin == BW'(BINS - 1));
  wire           last_blk = (blk == LB'(BLOCKS - 1));
  wire           period_end = in_valid && last_bin && last_blk;

  wire [BW-1:0]  ebin     = ecnt[BW-1:0];
  wire           epeak    = ecnt[BW];
  wire [SW-1:0]  esum     = sum_m[osel][ebin];
  wire [DW-1:0]  avg_w    = esum[SW-1:LB];
  wire [DW-1:0]  peak_w   = {ix_m[osel][ebin], pk_m[osel][ebin][DW-1:LB]};

  always_ff @(posedge clk) begin
    if (in_valid) begin
      sum_m[sel][in_bin] <= first ? SW'(in_power) : cur_sum + SW'(in_power);
      if (take) begin
        pk_m[sel][in_bin] <= in_power;
        ix_m[sel][in_bin] <= blk;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel       <= 1'b0;
      blk       <= '0;
      emit_on   <= 1'b0;
      ecnt      <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      if (in_valid && last_bin)
        blk <= last_blk ? '0 : blk + 1'b1;
      if (period_end) begin
        sel     <= ~sel;
        emit_on <= 1'b1;
        ecnt    <= '0;
      end else if (emit_on) begin
        ecnt <= ecnt + 1'b1;
        if (ecnt == AW'(2 * BINS - 1))
          emit_on <= 1'b0;
      end
      out_valid <= emit_on;
      if (emit_on) begin
        out_addr <= ecnt;
        out_data <= epeak ? peak_w : avg_w;
      end
    end
  end
endmodule

// File: rtl/pwr_bin_accum_chk.sv
module pwr_bin_accum_chk #(
  parameter int BINS = 256,
  parameter int BLOCKS = 128,
  localparam int BW = $clog2(BINS),
  localparam int LB = $clog2(BLOCKS),
  localparam int AW = BW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [BW-1:0] in_bin,
  input logic [LB-1:0] blk,
  input logic          out_valid,
  input logic [AW-1:0] out_addr
);
  // R6
  start_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_bin == BW'(BINS - 1) && blk == LB'(BLOCKS - 1)) |=> ##1 (out_valid && out_addr == '0));

  // R6
  first_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(out_valid)) |-> out_addr == '0);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> out_addr == $past(out_addr) + 1'b1);

  // R6
  last_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(out_addr) == AW'(2 * BINS - 1));

  // R9
  blk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> $stable(blk));
endmodule

bind pwr_bin_accum pwr_bin_accum_chk #(.BINS(BINS), .BLOCKS(BLOCKS)) chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_bin(in_bin), .blk(blk),
  .out_valid(out_valid), .out_addr(out_addr)
);

// File: tb/pwr_bin_accum_test.sv
`timescale 1ns/1ps
module pwr_bin_accum_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_bin = '0;
  logic [31:0] in_power = '0;
  wire out_valid;
  wire [8:0] out_addr;
  wire [31:0] out_data;

  pwr_bin_accum uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bin(in_bin), .in_power(in_power),
    .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int bad = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint unsigned m_sum [256];
  int unsigned m_pk [256];
  int unsigned m_ix [256];
  logic [31:0] e_word [512];
  int unsigned exp_start = 0;
  int widx = 0;
  int periods_done = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  function automatic string tag_of(int a);
    int b = a % 256;
    bit pk = (a >= 256);
    if (periods_done == 0) begin
      if (b == 0 && !pk) return "R8 avg";
      if ((b == 1 || b == 3) && pk) return "R4 tie";
      return pk ? "R3 peak" : "R2 avg";
    end
    if (b == 0 || b == 2) return "R5 fresh period";
    return "R7 overlapped period";
  endfunction

  function automatic logic [31:0] val(int p, int blk, int b);
    if (p == 0) begin
      case (b)
        0: return 32'hFFFF_FFFF;
        1: return 32'd5;
        2: return (blk == 127) ? 32'hFFFF_0000 : $urandom_range(1 << 20);
        3: return (blk == 10 || blk == 50) ? 32'h8000_0000 : $urandom_range(1000);
        default: return $urandom;
      endcase
    end
    case (b)
      0: return 32'd3;
      2: return (blk == 0) ? 32'h7000_0000 : $urandom_range(1000);
      default: return $urandom;
    endcase
  endfunction

  task automatic push(input int b, input int blk, input logic [31:0] p, input bit gaps);
    if (blk == 0) begin
      m_sum[b] = p;
      m_pk[b] = p;
      m_ix[b] = 0;
    end else begin
      m_sum[b] += p;
      if (p > m_pk[b]) begin
        m_pk[b] = p;
        m_ix[b] = blk;
      end
    end
    if (gaps && $urandom_range(7) == 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_power = 32'hDEAD_BEEF; // R9: ignored while in_valid is low
      in_bin = 8'(b + 1);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_bin = 8'(b);
    in_power = p;
    if (b == 255 && blk == 127) begin
      for (int i = 0; i < 256; i++) begin
        e_word[i] = m_sum[i][38:7];
        e_word[256 + i] = {m_ix[i][6:0], m_pk[i][31:7]};
      end
      exp_start = cyc + 2;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      check(cyc == exp_start + widx, "R6 timing", cyc, exp_start + widx);
      check(out_addr == 9'(widx), "R6 addr", out_addr, widx);
      check(out_data == e_word[widx], tag_of(widx), out_data, e_word[widx]);
      widx++;
      if (widx == 512) begin
        widx = 0;
        periods_done++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 during reset", out_valid, 0);
    rst = 1'b0;
    for (int p = 0; p < 2; p++) begin
      for (int blk = 0; blk < 128; blk++) begin
        for (int b = 0; b < 256; b++) begin
          push(b, blk, val(p, blk, b), p == 0);
          if (p == 0 && blk == 64 && b == 0)
            check(out_valid == 1'b0 && periods_done == 0, "R1 idle mid period", out_valid, 0);
        end
      end
      if (p == 0) begin
        check(e_word[0] == 32'hFFFF_FFFF, "R8 model", e_word[0], 32'hFFFF_FFFF);
        check(e_word[257] == 32'd0, "R4 model", e_word[257], 0);
        check(e_word[259][31:25] == 7'd10, "R4 model idx", e_word[259][31:25], 10);
        check(e_word[258][31:25] == 7'd127, "R3 model idx", e_word[258][31:25], 127);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (600) @(negedge clk);
    check(periods_done == 2 && widx == 0, "R6 count", periods_done, 2);
    check(out_valid == 1'b0, "R6 quiet after", out_valid, 0);
    report();
  end
endmodule